// File: doc/BRIEF.md
# Vectored Interrupt Message Controller

This block gathers a bank of device interrupt lines and turns each one into an 8-bit vector message for a processor-side vector controller. Software sets it up through a 32-bit register port. For each source it sets a trigger mode and a polarity, a mask bit, a message-enable bit, a vector number and a route byte. Pending edge events are latched. Level sources stay pending for as long as their line is active.

When a source is pending, unmasked, message-enabled and not in service, it is eligible to send. The lowest-numbered eligible source is placed on a valid/ready port as a {route, vector} pair. That pair is held until the port accepts it, and the source is then marked in service. Software ends the interrupt by writing a one to the source's bit in the clear register. After that a level source that is still active sends again, and an edge source waits for its next edge.

Top module: `vimc_top`

## Requirements
- R1: After reset every source is masked, every message-enable bit, pending bit and in-service bit is 0, every source is level-high (edge=0, polarity=0), and `msg_valid_o` is 0.
- R2: Every per-source bit register uses two 32-bit words. Source n is in word n/32 at bit n%32, and the second word is 4 bytes above the first. The words are at 0x20 (mask), 0x40 (message enable), 0x60 (edge mode) and 0x3E0 (polarity). A write changes only the bytes whose `reg_be_i` bit is set, and a read returns the stored value.
- R3: Trigger coding, as {edge, polarity}: 10 is a rising edge, 11 is a falling edge, 00 is level high and 01 is level low. Edges are detected on a two-flop synchronised copy of the input.
- R4: A source whose mask bit is 1, or whose message-enable bit is 0, never produces a message.
- R5: When several sources are eligible at once, the lowest-numbered source is sent first.
- R6: While `msg_valid_o` is 1 and `msg_ready_i` is 0, the valid signal, the vector and the route all stay unchanged.
- R7: Once a message is accepted, its source is in service and sends nothing more. Writing 1 to the source's bit at 0x80/0x84 clears the in-service state and any latched edge. Writing 0 to that bit has no effect.
- R8: After the clear, a level source whose line is still active sends again. An edge source does not send again until its next selected edge.
- R9: Source n has an 8-bit route at byte 0x100+n and an 8-bit vector at byte 0x200+n. Each byte can be written on its own lane. Within a word, byte lane j (data bits 8j+7:8j) holds source 4*(word index)+j.
- R10: A read of 0xA0/0xA4 returns the pending bits, with masking and enables not applied. A read of 0xA8/0xAC returns the in-service bits.
- R11: The words at 0xC0/0xC4 and 0xE0/0xE4 are plain read/write storage and have no effect on messages.
- R12: A read of an unmapped or misaligned offset, or of the write-only clear words, returns 0. A write to an unmapped offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC | Device interrupt lines, asynchronous |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | AW | Byte address |
| reg_be_i | input | 4 | Byte-lane enables for writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| msg_valid_o | output | 1 | Message available |
| msg_ready_i | input | 1 | Message accepted when high together with valid |
| msg_vec_o | output | 8 | Vector number of the message |
| msg_route_o | output | 8 | Route byte of the message |

## Verification
The bench builds the block with its defaults: 64 sources and a 10-bit address. Both words of every bit register are therefore in use, and so is the top-most address, the polarity words at 0x3E0. The tests use sources on both sides of the word boundary (2, 3, 5 in word 0; 33, 40, 63 in word 1). They exercise the byte-lane indexing of the route and vector tables, and priority between the lowest and highest source numbers.

// File: rtl/vimc_pkg.sv
package vimc_pkg;
  localparam int unsigned OFF_MASK  = 'h020;
  localparam int unsigned OFF_EN    = 'h040;
  localparam int unsigned OFF_EDGE  = 'h060;
  localparam int unsigned OFF_CLR   = 'h080;
  localparam int unsigned OFF_PEND  = 'h0A0;
  localparam int unsigned OFF_SVC   = 'h0A8;
  localparam int unsigned OFF_AUXA  = 'h0C0;
  localparam int unsigned OFF_AUXB  = 'h0E0;
  localparam int unsigned OFF_ROUTE = 'h100;
  localparam int unsigned OFF_VEC   = 'h200;
  localparam int unsigned OFF_POL   = 'h3E0;

  typedef struct packed {
    logic [7:0] route;
    logic [7:0] vec;
  } msg_t;
endpackage

// File: rtl/vimc_sync.sv
module vimc_sync #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] pol_i,
  output logic [NUM_SRC-1:0] act_o,
  output logic [NUM_SRC-1:0] evt_o
);
  logic [NUM_SRC-1:0] s1_q, s2_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      act_q <= '0;
    end else begin
      s1_q  <= irq_i;
      s2_q  <= s1_q;
      act_q <= act_o;
    end
  end

  assign act_o = s2_q ^ pol_i;
  assign evt_o = act_o & ~act_q;  // selected edge = rise of active level
endmodule

// File: rtl/vimc_regs.sv
module vimc_regs
  import vimc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned AW      = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [3:0]              be_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [NUM_SRC-1:0]      pend_i,
  input  logic [NUM_SRC-1:0]      svc_i,
  output logic [NUM_SRC-1:0]      mask_o,
  output logic [NUM_SRC-1:0]      en_o,
  output logic [NUM_SRC-1:0]      edge_o,
  output logic [NUM_SRC-1:0]      pol_o,
  output logic [NUM_SRC-1:0]      clr_o,
  output logic [NUM_SRC-1:0][7:0] route_o,
  output logic [NUM_SRC-1:0][7:0] vec_o
);
  localparam int unsigned NW = NUM_SRC / 32;
  localparam int unsigned WW = AW - 2;
  localparam logic [WW-1:0] WA_MASK  = WW'(OFF_MASK >> 2);
  localparam logic [WW-1:0] WA_EN    = WW'(OFF_EN >> 2);
  localparam logic [WW-1:0] WA_EDGE  = WW'(OFF_EDGE >> 2);
  localparam logic [WW-1:0] WA_CLR   = WW'(OFF_CLR >> 2);
  localparam logic [WW-1:0] WA_PEND  = WW'(OFF_PEND >> 2);
  localparam logic [WW-1:0] WA_SVC   = WW'(OFF_SVC >> 2);
  localparam logic [WW-1:0] WA_AUXA  = WW'(OFF_AUXA >> 2);
  localparam logic [WW-1:0] WA_AUXB  = WW'(OFF_AUXB >> 2);
  localparam logic [WW-1:0] WA_ROUTE = WW'(OFF_ROUTE >> 2);
  localparam logic [WW-1:0] WA_VEC   = WW'(OFF_VEC >> 2);
  localparam logic [WW-1:0] WA_POL   = WW'(OFF_POL >> 2);

  logic [NW-1:0][31:0] mask_q, en_q, edge_q, pol_q, auxa_q, auxb_q;
  logic [NUM_SRC-1:0][7:0] route_q, vec_q;
  logic [WW-1:0] wa;
  logic          acc, wr;
  logic [31:0]   bm;

  assign acc = req_i && (addr_i[1:0] == 2'b00);
  assign wr  = acc && we_i;
  assign wa  = addr_i[AW-1:2];
  always_comb for (int b = 0; b < 4; b++) bm[8*b +: 8] = {8{be_i[b]}};

  function automatic logic [31:0] upd(input logic [31:0] old, input logic [31:0] d,
                                      input logic [31:0] m);
    return (old & ~m) | (d & m);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      en_q    <= '0;
      edge_q  <= '0;
      pol_q   <= '0;
      auxa_q  <= '0;
      auxb_q  <= '0;
      route_q <= '0;
      vec_q   <= '0;
    end else if (wr) begin
      for (int w = 0; w < NW; w++) begin
        if (wa == WA_MASK + WW'(w)) mask_q[w] <= upd(mask_q[w], wdata_i, bm);
        if (wa == WA_EN   + WW'(w)) en_q[w]   <= upd(en_q[w],   wdata_i, bm);
        if (wa == WA_EDGE + WW'(w)) edge_q[w] <= upd(edge_q[w], wdata_i, bm);
        if (wa == WA_POL  + WW'(w)) pol_q[w]  <= upd(pol_q[w],  wdata_i, bm);
        if (wa == WA_AUXA + WW'(w)) auxa_q[w] <= upd(auxa_q[w], wdata_i, bm);
        if (wa == WA_AUXB + WW'(w)) auxb_q[w] <= upd(auxb_q[w], wdata_i, bm);
      end
      for (int i = 0; i < NUM_SRC; i++) begin
        if (be_i[i%4] && wa == WA_ROUTE + WW'(i/4)) route_q[i] <= wdata_i[8*(i%4) +: 8];
        if (be_i[i%4] && wa == WA_VEC   + WW'(i/4)) vec_q[i]   <= wdata_i[8*(i%4) +: 8];
      end
    end
  end

  // W1C pulse, one cycle
  always_comb begin
    clr_o = '0;
    for (int w = 0; w < NW; w++)
      if (wr && wa == WA_CLR + WW'(w)) clr_o[32*w +: 32] = wdata_i & bm;
  end

  always_comb begin
    rdata_o = '0;
    if (acc && !we_i) begin
      for (int w = 0; w < NW; w++) begin
        if (wa == WA_MASK + WW'(w)) rdata_o = mask_q[w];
        if (wa == WA_EN   + WW'(w)) rdata_o = en_q[w];
        if (wa == WA_EDGE + WW'(w)) rdata_o = edge_q[w];
        if (wa == WA_POL  + WW'(w)) rdata_o = pol_q[w];
        if (wa == WA_AUXA + WW'(w)) rdata_o = auxa_q[w];
        if (wa == WA_AUXB + WW'(w)) rdata_o = auxb_q[w];
        if (wa == WA_PEND + WW'(w)) rdata_o = pend_i[32*w +: 32];
        if (wa == WA_SVC  + WW'(w)) rdata_o = svc_i[32*w +: 32];
      end
      for (int i = 0; i < NUM_SRC; i++) begin
        if (wa == WA_ROUTE + WW'(i/4)) rdata_o[8*(i%4) +: 8] = route_q[i];
        if (wa == WA_VEC   + WW'(i/4)) rdata_o[8*(i%4) +: 8] = vec_q[i];
      end
    end
  end

  assign mask_o  = mask_q;
  assign en_o    = en_q;
  assign edge_o  = edge_q;
  assign pol_o   = pol_q;
  assign route_o = route_q;
  assign vec_o   = vec_q;
endmodule

// File: rtl/vimc_arb.sv
module vimc_arb
  import vimc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_SRC-1:0]      elig_i,
  input  logic [NUM_SRC-1:0][7:0] route_i,
  input  logic [NUM_SRC-1:0][7:0] vec_i,
  input  logic                    ready_i,
  output logic                    valid_o,
  output msg_t                    msg_o,
  output logic [NUM_SRC-1:0]      acc_o
);
  localparam int unsigned IW = $clog2(NUM_SRC);

  logic [IW-1:0] sel, idx_q;
  logic          any;

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (elig_i[i]) begin
        sel = IW'(i);
        any = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      msg_o   <= '0;
      idx_q   <= '0;
    end else if (!valid_o) begin
      if (any) begin
        valid_o   <= 1'b1;
        msg_o.route <= route_i[sel];
        msg_o.vec   <= vec_i[sel];
        idx_q     <= sel;
      end
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign acc_o = (valid_o && ready_i) ? (NUM_SRC'(1) << idx_q) : '0;
endmodule

// File: rtl/vimc_top.sv
module vimc_top
  import vimc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned AW      = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [3:0]         reg_be_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [7:0]         msg_vec_o,
  output logic [7:0]         msg_route_o
);
  logic [NUM_SRC-1:0] mask, en, edge_m, pol, clr, act, evt;
  logic [NUM_SRC-1:0] ep_q, svc_q, pend, elig, acc;
  logic [NUM_SRC-1:0][7:0] route, vec;
  msg_t msg;

  vimc_regs #(.NUM_SRC(NUM_SRC), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i), .be_i(reg_be_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .pend_i(pend), .svc_i(svc_q),
    .mask_o(mask), .en_o(en), .edge_o(edge_m), .pol_o(pol), .clr_o(clr),
    .route_o(route), .vec_o(vec)
  );

  vimc_sync #(.NUM_SRC(NUM_SRC)) u_sync (
    .clk_i, .rst_ni, .irq_i, .pol_i(pol), .act_o(act), .evt_o(evt)
  );

  // accept consumes a latched edge; an edge in the same cycle still latches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ep_q  <= '0;
      svc_q <= '0;
    end else begin
      ep_q  <= (ep_q & ~clr & ~acc) | (evt & edge_m);
      svc_q <= (svc_q & ~clr) | acc;
    end
  end

  assign pend = (edge_m & ep_q) | (~edge_m & act);
  assign elig = pend & ~mask & en & ~svc_q;

  vimc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk_i, .rst_ni, .elig_i(elig), .route_i(route), .vec_i(vec),
    .ready_i(msg_ready_i), .valid_o(msg_valid_o), .msg_o(msg), .acc_o(acc)
  );

  assign msg_vec_o   = msg.vec;
  assign msg_route_o = msg.route;
endmodule

// File: rtl/vimc_chk.sv
module vimc_chk #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned AW      = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_valid_o,
  input logic               msg_ready_i,
  input logic [7:0]         msg_vec_o,
  input logic [7:0]         msg_route_o,
  input logic               reg_req_i,
  input logic               reg_we_i,
  input logic [AW-1:0]      reg_addr_i,
  input logic [31:0]        reg_rdata_o,
  input logic [NUM_SRC-1:0] elig,
  input logic [NUM_SRC-1:0] acc,
  input logic [NUM_SRC-1:0] svc_q
);
  AST_MSG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_vec_o) && $stable(msg_route_o)); // R6

  AST_ACC_TO_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|acc) |=> ((svc_q & $past(acc)) == $past(acc))); // R7

  AST_SEND_NEEDS_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(|elig)); // R4

  AST_SINGLE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc)); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && reg_addr_i == '0 |-> reg_rdata_o == '0); // R12
endmodule

bind vimc_top vimc_chk #(.NUM_SRC(NUM_SRC), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
  .msg_vec_o(msg_vec_o), .msg_route_o(msg_route_o), .reg_req_i(reg_req_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .elig(elig), .acc(acc), .svc_q(svc_q)
);

// File: tb/vimc_top_bench.sv
module vimc_top_bench;
  localparam int unsigned N  = 64;
  localparam int unsigned AW = 10;

  logic          clk = 0, rst_n = 0;
  logic [N-1:0]  irq = '0;
  logic          req = 0, we = 0, rdy = 0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wdata = '0, rdata;
  logic          vld;
  logic [7:0]    vec, route;
  int            checks = 0, errors = 0;
  logic [31:0]   rv;

  always #2 clk = ~clk;

  vimc_top #(.NUM_SRC(N), .AW(AW)) u_vimc_top (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_be_i(be), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .msg_valid_o(vld), .msg_ready_i(rdy), .msg_vec_o(vec), .msg_route_o(route)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1; we = 1; addr = AW'(a); wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0; be = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = AW'(a);
    #1 d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_msg(input string r, input logic [7:0] ev, input logic [7:0] er);
    int n = 0;
    @(negedge clk);
    while (!vld && n < 20) begin @(negedge clk); n++; end
    check(r, {24'h0, vld, 7'h0}, 32'h80);
    check(r, {16'h0, route, vec}, {16'h0, er, ev});
  endtask

  task automatic no_msg(input string r, input int cyc);
    int seen = 0;
    for (int k = 0; k < cyc; k++) begin @(negedge clk); if (vld) seen = 1; end
    check(r, seen, 0);
  endtask

  task automatic accept();
    @(negedge clk); rdy = 1;
    @(negedge clk); rdy = 0;
  endtask

  task automatic t_reset();
    rd('h20, rv); check("R1 mask0", rv, 32'hFFFF_FFFF);
    rd('h24, rv); check("R1 mask1", rv, 32'hFFFF_FFFF);
    rd('h44, rv); check("R1 en", rv, 0);
    rd('h60, rv); check("R1 edge", rv, 0);
    rd('h3E4, rv); check("R1 pol", rv, 0);
    rd('hA0, rv); check("R1 pend", rv, 0);
    rd('hA8, rv); check("R1 svc", rv, 0);
    check("R1 valid", {31'h0, vld}, 0);
  endtask

  task automatic t_regmap();
    wr('h40, 32'hFFFF_FFFF, 4'b0010);
    rd('h40, rv); check("R2 byte lane", rv, 32'h0000_FF00);
    wr('h40, 32'h0);
    wr('h3E4, 32'h1234_5678);
    rd('h3E4, rv); check("R2 pol word1", rv, 32'h1234_5678);
    wr('h3E4, 32'h0);
  endtask

  task automatic t_unmapped();
    wr('h010, 32'hDEAD_BEEF);
    wr('h022, 32'h0);
    rd('h010, rv); check("R12 unmapped rd", rv, 0);
    rd('h80, rv);  check("R12 clr rd", rv, 0);
    rd('h20, rv);  check("R12 no side write", rv, 32'hFFFF_FFFF);
  endtask

  task automatic t_aux();
    wr('hC0, 32'hA5A5_5A5A);
    wr('hE4, 32'h0000_1234);
    rd('hC0, rv); check("R11 auxa", rv, 32'hA5A5_5A5A);
    rd('hE4, rv); check("R11 auxb", rv, 32'h0000_1234);
    no_msg("R11 no msg", 5);
  endtask

  task automatic t_tables();
    wr('h104, 32'h4433_2211);
    wr('h204, 32'h0099_0000, 4'b0100);
    wr('h204, 32'h0000_5500, 4'b0010);
    rd('h204, rv); check("R9 vec lanes", rv, 32'h0099_5500);
    rd('h104, rv); check("R9 route", rv, 32'h4433_2211);
  endtask

  task automatic t_level();
    wr('h40, 32'h20);
    wr('h20, ~32'h20);
    irq[5] = 1;
    wait_msg("R3 level high src5", 8'h55, 8'h22);
    repeat (3) @(negedge clk);
    check("R6 hold", {24'h0, vld, vec[6:0]}, {24'h0, 1'b1, 7'h55});
    accept();
    @(negedge clk); check("R7 valid drop", {31'h0, vld}, 0);
    rd('hA8, rv); check("R7 svc bit", rv, 32'h20);
    rd('hA0, rv); check("R10 pend", rv, 32'h20);
    no_msg("R7 no resend", 10);
    wr('h80, 32'hFFFF_FFDF);
    no_msg("R7 clear zero", 6);
    rd('hA8, rv); check("R7 svc kept", rv, 32'h20);
    wr('h80, 32'h20);
    wait_msg("R8 level resend", 8'h55, 8'h22);
    accept();
    irq[5] = 0;
    wr('h80, 32'h20);
    no_msg("R8 level idle", 8);
  endtask

  task automatic t_mask();
    wr('h20, 32'hFFFF_FFFF);
    irq[5] = 1;
    no_msg("R4 masked", 10);
    rd('hA0, rv); check("R10 raw pend masked", rv, 32'h20);
    wr('h40, 32'h0);
    wr('h20, ~32'h20);
    no_msg("R4 disabled", 10);
    irq[5] = 0;
    wr('h20, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    wr('h220, 32'h0000_3300, 4'b0010);
    wr('h120, 32'h0000_7700, 4'b0010);
    wr('h64, 32'h2);
    wr('h44, 32'h2);
    wr('h24, ~32'h2);
    irq[33] = 1;
    wait_msg("R3 rising src33", 8'h33, 8'h77);
    accept();
    wr('h84, 32'h2);
    no_msg("R8 edge no resend", 10);
    wr('h3E4, 32'h2);
    no_msg("R3 pol flip quiet", 6);
    irq[33] = 0;
    wait_msg("R3 falling src33", 8'h33, 8'h77);
    accept();
    wr('h84, 32'h2);
    wr('h228, 32'h40, 4'b0001);
    wr('h3E4, 32'h102);
    wr('h44, 32'h102);
    wr('h24, ~32'h102);
    wait_msg("R3 level low src40", 8'h40, 8'h00);
    accept();
    wr('h24, 32'hFFFF_FFFF);
    wr('h84, 32'h102);
    no_msg("R4 all masked", 6);
  endtask

  task automatic t_prio();
    wr('h200, 32'hA3A2_0000, 4'b1100);
    wr('h23C, 32'hBF00_0000, 4'b1000);
    wr('h40, 32'hC);
    wr('h44, 32'h8000_0000);
    wr('h20, ~32'hC);
    wr('h24, ~32'h8000_0000);
    irq[63] = 1; irq[3] = 1; irq[2] = 1;
    wait_msg("R5 first src2", 8'hA2, 8'h00);
    accept();
    wait_msg("R5 second src3", 8'hA3, 8'h00);
    accept();
    wait_msg("R5 third src63", 8'hBF, 8'h00);
    accept();
    irq[63] = 0; irq[3] = 0; irq[2] = 0;
    wr('h80, 32'hC);
    wr('h84, 32'h8000_0000);
    no_msg("R5 idle", 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regmap();
    t_unmapped();
    t_aux();
    t_tables();
    t_level();
    t_mask();
    t_edge();
    t_prio();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule